// File: doc/BRIEF.md
# Decode-Stage Static Branch Predictor

This block sits in the decode stage of an in-order pipeline. Each cycle it may receive one fetched 32-bit instruction word and the address it was fetched from. For the two relative branch forms it makes a static direction guess. Unconditional relative branches are always guessed taken. Conditional relative branches are guessed taken only when their displacement is negative, which favours backward loop branches. Branches that take their target from the link or count register are always guessed not taken, because decode cannot know their target. A taken guess sends a flush and a redirect to the computed target back toward fetch. The guess bit then travels down the pipe registered alongside the instruction.

At the execute end, a companion check compares the resolved direction with the guess carried by the branch. It asks for a corrective redirect only when the two disagree. A taken branch that was guessed not taken goes to its target. A not-taken branch that was guessed taken goes to the next sequential word. A single registered arbiter merges both redirect sources toward fetch, and the execute-side source wins a same-cycle collision. Execute redirects also squash the instruction that decode is handing down in that cycle.

Top module: `bpred_top`

## Requirements
- R1: An instruction with primary opcode 18 (bits 31:26) is predicted taken whatever the sign of its 24-bit displacement (bits 25:2, sign-extended, times 4). One cycle later, fetch gets a redirect to address + displacement, flagged as coming from decode.
- R2: An instruction with primary opcode 16 is predicted taken, with a redirect to address + displacement (bits 15:2, sign-extended, times 4), exactly when bit 15 is 1. A zero or positive displacement is predicted not taken and produces no redirect.
- R3: When bit 1 (absolute mode) of an opcode 18 or 16 branch is set, the predicted target is the sign-extended displacement itself.
- R4: Opcode 19 with extended opcode 16 or 528 (bits 10:1), the register-target branches, is always predicted not taken and produces no redirect.
- R5: Any other instruction word is predicted not taken and produces no decode redirect.
- R6: One cycle after a valid decode input, the downstream outputs present that instruction word, its address and its prediction bit, with the valid bit set.
- R7: The execute check requests nothing when the resolved direction equals the carried prediction. A branch resolved taken but predicted not taken redirects to its resolved target one cycle later, flagged as coming from execute.
- R8: A branch predicted taken but resolved not taken redirects to its address + 4.
- R9: When execute and decode both request a redirect in one cycle, the execute address and source flag are presented.
- R10: An execute redirect squashes the decode instruction of the same cycle, so no downstream valid follows it.
- R11: After reset, the redirect valid, source flag and downstream valid are all 0.
- R12: With the decode valid input low, no decode redirect and no downstream valid follow, whatever the instruction word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid_i | input | 1 | Decode input holds an instruction |
| dec_insn_i | input | 32 | Fetched instruction word |
| dec_pc_i | input | ADDR_W | Address of the instruction |
| ex_valid_i | input | 1 | Execute holds a resolved branch |
| ex_pred_i | input | 1 | Prediction bit carried by that branch |
| ex_taken_i | input | 1 | Resolved direction |
| ex_target_i | input | ADDR_W | Resolved taken target |
| ex_pc_i | input | ADDR_W | Address of the resolved branch |
| dn_valid_o | output | 1 | Downstream instruction valid |
| dn_insn_o | output | 32 | Downstream instruction word |
| dn_pc_o | output | ADDR_W | Downstream instruction address |
| dn_pred_o | output | 1 | Downstream prediction bit |
| redir_valid_o | output | 1 | Flush plus redirect toward fetch |
| redir_addr_o | output | ADDR_W | Redirect address |
| redir_from_ex_o | output | 1 | 1 when the redirect came from execute |

## Verification
The bench goes after the sign boundary of the conditional displacement. A zero displacement must stay not taken, and a predictor that tested for non-positive values would redirect there. Absolute-mode branches with negative displacements catch a design that adds the address anyway or fails to sign-extend to the full width. Register-target forms catch a predictor keyed on opcode alone. Same-cycle collisions and wrong-way mispredicts catch a design that lets decode override execute, forgets to squash the decoded word, or sends a guessed-taken branch to its target instead of the next word.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

    typedef enum logic [1:0] {
        BK_NONE = 2'd0,
        BK_REL  = 2'd1,
        BK_COND = 2'd2,
        BK_REG  = 2'd3
    } br_kind_e;

    localparam logic [5:0] OPC_REL  = 6'd18;
    localparam logic [5:0] OPC_COND = 6'd16;
    localparam logic [5:0] OPC_XL   = 6'd19;
    localparam logic [9:0] XO_LINK  = 10'd16;
    localparam logic [9:0] XO_COUNT = 10'd528;

    typedef struct packed {
        br_kind_e kind;
        logic     abs_mode;
        logic     taken;
    } guess_t;

    function automatic br_kind_e classify(input logic [31:1] w);
        br_kind_e k;
        k = BK_NONE;
        if (w[31:26] == OPC_REL)
            k = BK_REL;
        else if (w[31:26] == OPC_COND)
            k = BK_COND;
        else if (w[31:26] == OPC_XL && (w[10:1] == XO_LINK || w[10:1] == XO_COUNT))
            k = BK_REG;
        return k;
    endfunction

endpackage

// File: rtl/bp_decode.sv
module bp_decode
    import bpred_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              valid_i,
    input  logic [31:1]       insn_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic              pred_o,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int REL_PAD  = ADDR_W - 26;
    localparam int COND_PAD = ADDR_W - 16;

    guess_t            g;
    logic [ADDR_W-1:0] disp;

    always_comb begin
        g.kind     = classify(insn_i);
        g.abs_mode = insn_i[1];
        g.taken    = 1'b0;
        disp       = '0;
        case (g.kind)
            BK_REL: begin
                disp    = {{REL_PAD{insn_i[25]}}, insn_i[25:2], 2'b00};
                g.taken = 1'b1;
            end
            BK_COND: begin
                disp    = {{COND_PAD{insn_i[15]}}, insn_i[15:2], 2'b00};
                g.taken = insn_i[15];
            end
            default: begin
                disp    = '0;
                g.taken = 1'b0;
            end
        endcase
    end

    assign pred_o = valid_i & g.taken;
    assign req_o  = pred_o;
    assign addr_o = g.abs_mode ? disp : (pc_i + disp);

endmodule

// File: rtl/bp_exec_check.sv
module bp_exec_check #(
    parameter int ADDR_W = 32
) (
    input  logic              valid_i,
    input  logic              pred_i,
    input  logic              taken_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    assign req_o  = valid_i & (pred_i ^ taken_i);
    assign addr_o = taken_i ? target_i : (pc_i + STEP);

endmodule

// File: rtl/bp_redirect_arb.sv
module bp_redirect_arb #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ex_req_i,
    input  logic [ADDR_W-1:0] ex_addr_i,
    input  logic              dec_req_i,
    input  logic [ADDR_W-1:0] dec_addr_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              from_ex_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o   <= 1'b0;
            from_ex_o <= 1'b0;
            addr_o    <= '0;
        end else if (ex_req_i) begin
            valid_o   <= 1'b1;
            from_ex_o <= 1'b1;
            addr_o    <= ex_addr_i;
        end else if (dec_req_i) begin
            valid_o   <= 1'b1;
            from_ex_o <= 1'b0;
            addr_o    <= dec_addr_i;
        end else begin
            valid_o   <= 1'b0;
            from_ex_o <= 1'b0;
        end
    end

    // R9: execute wins a collision
    assert_ex_priority_R9: assert property (@(posedge clk) disable iff (rst)
        ex_req_i |=> (valid_o && from_ex_o && addr_o == $past(ex_addr_i)));

    // R1: decode-only request is tagged as decode
    assert_dec_source_R1: assert property (@(posedge clk) disable iff (rst)
        (dec_req_i && !ex_req_i) |=> (valid_o && !from_ex_o));

    // R5: no request, no redirect
    assert_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (!dec_req_i && !ex_req_i) |=> !valid_o);

endmodule

// File: rtl/bpred_top.sv
module bpred_top
    import bpred_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_valid_i,
    input  logic [31:0]       dec_insn_i,
    input  logic [ADDR_W-1:0] dec_pc_i,
    input  logic              ex_valid_i,
    input  logic              ex_pred_i,
    input  logic              ex_taken_i,
    input  logic [ADDR_W-1:0] ex_target_i,
    input  logic [ADDR_W-1:0] ex_pc_i,
    output logic              dn_valid_o,
    output logic [31:0]       dn_insn_o,
    output logic [ADDR_W-1:0] dn_pc_o,
    output logic              dn_pred_o,
    output logic              redir_valid_o,
    output logic [ADDR_W-1:0] redir_addr_o,
    output logic              redir_from_ex_o
);
    logic              dec_pred;
    logic              dec_req;
    logic [ADDR_W-1:0] dec_addr;
    logic              ex_req;
    logic [ADDR_W-1:0] ex_addr;

    bp_decode #(.ADDR_W(ADDR_W)) u_decode (
        .valid_i (dec_valid_i),
        .insn_i  (dec_insn_i[31:1]),
        .pc_i    (dec_pc_i),
        .pred_o  (dec_pred),
        .req_o   (dec_req),
        .addr_o  (dec_addr)
    );

    bp_exec_check #(.ADDR_W(ADDR_W)) u_check (
        .valid_i  (ex_valid_i),
        .pred_i   (ex_pred_i),
        .taken_i  (ex_taken_i),
        .target_i (ex_target_i),
        .pc_i     (ex_pc_i),
        .req_o    (ex_req),
        .addr_o   (ex_addr)
    );

    bp_redirect_arb #(.ADDR_W(ADDR_W)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .ex_req_i   (ex_req),
        .ex_addr_i  (ex_addr),
        .dec_req_i  (dec_req),
        .dec_addr_i (dec_addr),
        .valid_o    (redir_valid_o),
        .addr_o     (redir_addr_o),
        .from_ex_o  (redir_from_ex_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dn_valid_o <= 1'b0;
            dn_pred_o  <= 1'b0;
            dn_insn_o  <= '0;
            dn_pc_o    <= '0;
        end else begin
            dn_valid_o <= dec_valid_i & ~ex_req;
            dn_pred_o  <= dec_pred;
            dn_insn_o  <= dec_insn_i;
            dn_pc_o    <= dec_pc_i;
        end
    end

    // R6: an unsquashed decode input appears downstream next cycle
    assert_pass_down_R6: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_i && !ex_req) |=> (dn_valid_o && dn_insn_o == $past(dec_insn_i)));

    // R10: execute redirect squashes the decoded word
    assert_squash_R10: assert property (@(posedge clk) disable iff (rst)
        ex_req |=> !dn_valid_o);

    // R4: register-target forms never carry a taken guess
    assert_reg_form_R4: assert property (@(posedge clk) disable iff (rst)
        (dec_insn_i[31:26] == OPC_XL) |=> !dn_pred_o);

    // R7: agreement between guess and outcome never yields an execute redirect
    assert_agree_R7: assert property (@(posedge clk) disable iff (rst)
        (ex_pred_i == ex_taken_i) |=> !redir_from_ex_o);

    // R12: idle decode input gives no downstream valid
    assert_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !dec_valid_i |=> !dn_valid_o);

endmodule

// File: tb/tb_bpred_top.sv
module tb_bpred_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          dec_valid_i;
    logic [31:0]   dec_insn_i;
    logic [AW-1:0] dec_pc_i;
    logic          ex_valid_i, ex_pred_i, ex_taken_i;
    logic [AW-1:0] ex_target_i, ex_pc_i;
    logic          dn_valid_o, dn_pred_o;
    logic [31:0]   dn_insn_o;
    logic [AW-1:0] dn_pc_o;
    logic          redir_valid_o, redir_from_ex_o;
    logic [AW-1:0] redir_addr_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    bpred_top #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst),
        .dec_valid_i(dec_valid_i), .dec_insn_i(dec_insn_i), .dec_pc_i(dec_pc_i),
        .ex_valid_i(ex_valid_i), .ex_pred_i(ex_pred_i), .ex_taken_i(ex_taken_i),
        .ex_target_i(ex_target_i), .ex_pc_i(ex_pc_i),
        .dn_valid_o(dn_valid_o), .dn_insn_o(dn_insn_o), .dn_pc_o(dn_pc_o),
        .dn_pred_o(dn_pred_o), .redir_valid_o(redir_valid_o),
        .redir_addr_o(redir_addr_o), .redir_from_ex_o(redir_from_ex_o)
    );

    // {insn, expected guess, expected redirect address}
    localparam int NV = 11;
    localparam logic [64:0] VEC [NV] = '{
        {32'h4800_0040, 1'b1, 32'h0000_1040},   // R1 forward
        {32'h4BFF_FF00, 1'b1, 32'h0000_0F00},   // R1 backward
        {32'h4000_0020, 1'b0, 32'h0000_0000},   // R2 positive
        {32'h4000_FFF0, 1'b1, 32'h0000_0FF0},   // R2 negative
        {32'h4800_0202, 1'b1, 32'h0000_0200},   // R3 absolute
        {32'h4000_FFFA, 1'b1, 32'hFFFF_FFF8},   // R3 absolute negative
        {32'h4C00_0020, 1'b0, 32'h0000_0000},   // R4 link form
        {32'h4C00_0420, 1'b0, 32'h0000_0000},   // R4 count form
        {32'h7C00_0214, 1'b0, 32'h0000_0000},   // R5 other
        {32'h4000_0000, 1'b0, 32'h0000_0000},   // R2 zero displacement
        {32'h4800_0005, 1'b1, 32'h0000_1004}    // R1 with link bit
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        dec_valid_i = 0; dec_insn_i = '0; dec_pc_i = '0;
        ex_valid_i = 0; ex_pred_i = 0; ex_taken_i = 0; ex_target_i = '0; ex_pc_i = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<5000", cycles);
            finish_run();
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        // R11: reset state
        chk("R11 redir_valid", 64'(redir_valid_o), 64'd0);
        chk("R11 from_ex", 64'(redir_from_ex_o), 64'd0);
        chk("R11 dn_valid", 64'(dn_valid_o), 64'd0);

        for (int i = 0; i < NV; i++) begin
            dec_valid_i = 1; dec_insn_i = VEC[i][64:33]; dec_pc_i = 32'h0000_1000;
            @(negedge clk);
            chk($sformatf("R1-5 vec%0d guess", i), 64'(dn_pred_o), 64'(VEC[i][32]));
            chk($sformatf("R1-5 vec%0d redirect", i), 64'(redir_valid_o), 64'(VEC[i][32]));
            if (VEC[i][32]) begin
                chk($sformatf("R1-3 vec%0d addr", i), 64'(redir_addr_o), 64'(VEC[i][31:0]));
                chk($sformatf("R1 vec%0d src", i), 64'(redir_from_ex_o), 64'd0);
            end
            chk($sformatf("R6 vec%0d valid", i), 64'(dn_valid_o), 64'd1);
            chk($sformatf("R6 vec%0d insn", i), 64'(dn_insn_o), 64'(VEC[i][64:33]));
            chk($sformatf("R6 vec%0d pc", i), 64'(dn_pc_o), 64'h1000);
        end

        // R12: valid low with a taken-form word
        idle_inputs(); dec_insn_i = 32'h4800_0040; dec_pc_i = 32'h1000;
        @(negedge clk);
        chk("R12 redirect", 64'(redir_valid_o), 64'd0);
        chk("R12 dn_valid", 64'(dn_valid_o), 64'd0);

        // R7: taken but guessed not taken
        idle_inputs(); ex_valid_i = 1; ex_pred_i = 0; ex_taken_i = 1;
        ex_target_i = 32'h2000; ex_pc_i = 32'h1800;
        @(negedge clk);
        chk("R7 redirect", 64'(redir_valid_o), 64'd1);
        chk("R7 addr", 64'(redir_addr_o), 64'h2000);
        chk("R7 src", 64'(redir_from_ex_o), 64'd1);

        // R7: agreement, no redirect
        ex_pred_i = 1; ex_taken_i = 1;
        @(negedge clk);
        chk("R7 agree", 64'(redir_valid_o), 64'd0);

        // R8: guessed taken, not taken
        ex_pred_i = 1; ex_taken_i = 0; ex_pc_i = 32'h3000;
        @(negedge clk);
        chk("R8 redirect", 64'(redir_valid_o), 64'd1);
        chk("R8 addr", 64'(redir_addr_o), 64'h3004);

        // R9/R10: collision
        ex_pred_i = 0; ex_taken_i = 1; ex_target_i = 32'h5000;
        dec_valid_i = 1; dec_insn_i = 32'h4800_0040; dec_pc_i = 32'h1000;
        @(negedge clk);
        chk("R9 addr", 64'(redir_addr_o), 64'h5000);
        chk("R9 src", 64'(redir_from_ex_o), 64'd1);
        chk("R10 squash", 64'(dn_valid_o), 64'd0);

        idle_inputs();
        @(negedge clk);
        chk("R5 quiet after", 64'(redir_valid_o), 64'd0);
        finish_run();
    end
endmodule